// File: doc/BRIEF.md
# Per-Bit Attribute Control and Status Register Bank

This block is a compact register bank in which every bit has its own access behaviour, chosen by parameter from a fixed set. The set holds nine behaviours: reserved, read-only status, write-only control, read/write, write-one-to-clear, clear-on-read, latch-low, latch-high and self-clearing. A separate per-bit mask marks storage bits that survive a software reset. A host reaches the bank over a plain address/data bus with separate read and write strobes. Hardware supplies one input per bit. That input is the level for read-only bits, the set event for write-one-to-clear, clear-on-read and latch-high bits, and the monitored level for latch-low bits.

Three reset sources restore the programmed defaults. The first is an asynchronous power-on reset. The second is a synchronous system reset. The third is a synchronous software reset, which spares the immune bits. A register whose bits are all reserved counts as a reserved address. Read data is registered and appears one clock after the read strobe. A flat output carries the stored value of every storage bit to the hardware side.

Top module: `csr_bank`

## Requirements
- R1: On power-on reset every storage bit loads its default and `rdata_o` is 0. Read data is updated only on the clock edge that samples `rd_i` high and holds otherwise.
- R2: A write to a read/write or write-only bit stores the written value and drives it on `field_o`. A read/write bit reads back its value. A write-only bit always reads 0.
- R3: A read-only bit reads the current level of its hardware input, and host writes have no effect on it.
- R4: A write-one-to-clear bit is set while its hardware input is 1. Writing 1 to it clears it. Writing 0 leaves it unchanged.
- R5: A clear-on-read bit is set while its hardware input is 1 and is cleared by a host read of its register. Host writes do not change it.
- R6: A latch-high bit goes to 1 when its input is high and holds until read. A latch-low bit goes to 0 when its input is low and holds until read. A read returns the held value and then re-arms the bit: to 0 for latch-high, to 1 for latch-low.
- R7: A self-clearing bit is set by writing 1 and returns to 0 one clock later. A read issued in the same cycle as that write returns 1 for the bit.
- R8: A software reset loads the default into every storage bit, except bits marked immune, which keep their value.
- R9: A system reset loads the default into every storage bit, immune bits included.
- R10: Reserved bits read 0. Reads of reserved or unmapped addresses return 0, and writes to them are ignored.
- R11: When a hardware set or latch event falls in the same cycle as a read-clear or a write-one-clear of that bit, the event wins and the bit takes its event value. The read in that cycle still returns the value held before the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| sys_rst_i | input | 1 | Synchronous system reset, all bits |
| soft_rst_i | input | 1 | Synchronous software reset, immune bits kept |
| addr_i | input | ADDR_W | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | DATA_W | Write data |
| hw_i | input | NUM_REGS*DATA_W | Per-bit hardware level or event input |
| rdata_o | output | DATA_W | Registered read data |
| field_o | output | NUM_REGS*DATA_W | Stored value of every storage bit, 0 elsewhere |

## Verification
Two operations can land on the same bit in the same cycle. One is a hardware event, which sets a write-one-to-clear, clear-on-read or latch-high bit, or pulls a latch-low bit low. The other is a host clear, either a read of the register or a write of 1. The bench drives the event input high together with a clearing write, and high or low together with a read strobe. It then judges two things: the read returns the value held before the event, and a follow-up read shows the bit at its event value. A second collision pairs a setting write to a self-clearing bit with a read in the same cycle. That read must return 1, and the stored bit must be gone one cycle later.

// File: rtl/csr_attr_pkg.sv
package csr_attr_pkg;
  typedef enum logic [3:0] {
    ATTR_RSVD = 4'd0,
    ATTR_RO   = 4'd1,
    ATTR_WO   = 4'd2,
    ATTR_RW   = 4'd3,
    ATTR_W1C  = 4'd4,
    ATTR_RC   = 4'd5,
    ATTR_LL   = 4'd6,
    ATTR_LH   = 4'd7,
    ATTR_SC   = 4'd8
  } attr_e;

  localparam int unsigned ATTR_W = 4;
endpackage

// File: rtl/csr_bit.sv
module csr_bit
  import csr_attr_pkg::*;
#(
  parameter attr_e ATTR = ATTR_RW,
  parameter bit    DEF  = 1'b0,
  parameter bit    KEEP = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sys_rst_i,
  input  logic soft_rst_i,
  input  logic wr_hit_i,
  input  logic rd_hit_i,
  input  logic wdata_i,
  input  logic hw_i,
  output logic q_o,
  output logic view_o
);
  logic q;
  logic load_def;
  logic wr_one;
  logic any_rst;

  assign load_def = sys_rst_i | (soft_rst_i & ~KEEP);
  assign wr_one   = wr_hit_i & wdata_i;
  assign any_rst  = sys_rst_i | soft_rst_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= DEF;
    end else if (load_def) begin
      q <= DEF;
    end else begin
      case (ATTR)
        ATTR_WO, ATTR_RW: if (wr_hit_i) q <= wdata_i;
        ATTR_W1C: begin
          if (hw_i)        q <= 1'b1;
          else if (wr_one) q <= 1'b0;
        end
        ATTR_RC, ATTR_LH: begin
          if (hw_i)          q <= 1'b1;
          else if (rd_hit_i) q <= 1'b0;
        end
        ATTR_LL: begin
          if (!hw_i)         q <= 1'b0;
          else if (rd_hit_i) q <= 1'b1;
        end
        ATTR_SC: q <= wr_one;
        default: q <= q;
      endcase
    end
  end

  always_comb begin
    case (ATTR)
      ATTR_RO:           view_o = hw_i;
      ATTR_WO, ATTR_RSVD: view_o = 1'b0;
      ATTR_SC:           view_o = q | wr_one;  // same-cycle set visible
      default:           view_o = q;
    endcase
  end

  assign q_o = (ATTR == ATTR_RO || ATTR == ATTR_RSVD) ? 1'b0 : q;

  generate
    if (ATTR == ATTR_WO || ATTR == ATTR_RW) begin : g_ast_wr
      AST_WRITE_STORES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_hit_i && !any_rst) |=> (q == $past(wdata_i))); // R2
    end
    if (ATTR == ATTR_W1C) begin : g_ast_w1c
      AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_one && !hw_i && !any_rst) |=> !q); // R4
    end
    if (ATTR == ATTR_W1C || ATTR == ATTR_RC || ATTR == ATTR_LH) begin : g_ast_set
      AST_EVENT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hw_i && !any_rst) |=> q); // R11
    end
    if (ATTR == ATTR_RC || ATTR == ATTR_LH) begin : g_ast_rc
      AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_hit_i && !hw_i && !any_rst) |=> !q); // R5
    end
    if (ATTR == ATTR_LL) begin : g_ast_ll
      AST_LL_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!hw_i && !any_rst) |=> !q); // R6
      AST_LL_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_hit_i && hw_i && !any_rst) |=> q); // R6
    end
    if (ATTR == ATTR_SC) begin : g_ast_sc
      AST_SC_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q && !wr_one && !any_rst) |=> !q); // R7
    end
    if (ATTR != ATTR_RO && ATTR != ATTR_RSVD) begin : g_ast_rst
      AST_SYS_DEFAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sys_rst_i |=> (q == DEF)); // R9
      if (!KEEP) begin : g_plain
        AST_SOFT_DEFAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
          soft_rst_i |=> (q == DEF)); // R8
      end
    end
    if (KEEP && (ATTR == ATTR_RW || ATTR == ATTR_WO)) begin : g_ast_keep
      AST_SOFT_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (soft_rst_i && !sys_rst_i && !wr_hit_i) |=> $stable(q)); // R8
    end
  endgenerate
endmodule

// File: rtl/csr_decode.sv
module csr_decode #(
  parameter int unsigned          NUM_REGS = 4,
  parameter int unsigned          ADDR_W   = 3,
  parameter logic [NUM_REGS-1:0]  REG_USED = '1
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_i,
  input  logic                rd_i,
  output logic [NUM_REGS-1:0] sel_o,
  output logic [NUM_REGS-1:0] wr_hit_o,
  output logic [NUM_REGS-1:0] rd_hit_o
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    assign sel_o[r]    = (addr_i == ADDR_W'(r)) && REG_USED[r];
    assign wr_hit_o[r] = sel_o[r] & wr_i;
    assign rd_hit_o[r] = sel_o[r] & rd_i;
  end
endmodule

// File: rtl/csr_rdmux.sv
module csr_rdmux #(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned DATA_W   = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         rd_i,
  input  logic [NUM_REGS-1:0]          sel_i,
  input  logic [NUM_REGS*DATA_W-1:0]   view_i,
  output logic [DATA_W-1:0]            rdata_o
);
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    rdata_d = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (sel_i[r]) rdata_d = rdata_d | view_i[r*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rdata_d;
  end

  AST_RSVD_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !(|sel_i)) |=> (rdata_o == '0)); // R10
  AST_RDATA_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o)); // R1
endmodule

// File: rtl/csr_bank.sv
module csr_bank
  import csr_attr_pkg::*;
#(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ADDR_W   = 3,
  // 4-bit attribute code per bit, bit 0 of register 0 in the lowest nibble
  parameter logic [NUM_REGS*DATA_W*ATTR_W-1:0] ATTR_MAP =
    128'h3333_3333_0000_0000_0176_5544_0188_2333,
  parameter logic [NUM_REGS*DATA_W-1:0] DEF_MAP  = 32'hA500_1005,
  parameter logic [NUM_REGS*DATA_W-1:0] KEEP_MAP = 32'hF000_0004
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sys_rst_i,
  input  logic                       soft_rst_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic                       wr_i,
  input  logic                       rd_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic [NUM_REGS*DATA_W-1:0] hw_i,
  output logic [DATA_W-1:0]          rdata_o,
  output logic [NUM_REGS*DATA_W-1:0] field_o
);
  localparam int unsigned NBITS = NUM_REGS * DATA_W;

  function automatic logic [NUM_REGS-1:0] calc_used();
    logic [NUM_REGS-1:0] v;
    v = '0;
    for (int r = 0; r < NUM_REGS; r++)
      for (int b = 0; b < DATA_W; b++)
        if (ATTR_MAP[(r*DATA_W+b)*ATTR_W +: ATTR_W] != '0) v[r] = 1'b1;
    return v;
  endfunction

  localparam logic [NUM_REGS-1:0] REG_USED = calc_used();

  logic [NUM_REGS-1:0] sel;
  logic [NUM_REGS-1:0] wr_hit;
  logic [NUM_REGS-1:0] rd_hit;
  logic [NBITS-1:0]    view;

  csr_decode #(
    .NUM_REGS(NUM_REGS),
    .ADDR_W  (ADDR_W),
    .REG_USED(REG_USED)
  ) u_decode (
    .addr_i  (addr_i),
    .wr_i    (wr_i),
    .rd_i    (rd_i),
    .sel_o   (sel),
    .wr_hit_o(wr_hit),
    .rd_hit_o(rd_hit)
  );

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      localparam int unsigned IDX = r * DATA_W + b;
      localparam attr_e A = attr_e'(ATTR_MAP[IDX*ATTR_W +: ATTR_W]);
      csr_bit #(
        .ATTR(A),
        .DEF (DEF_MAP[IDX]),
        .KEEP(KEEP_MAP[IDX])
      ) u_bit (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .sys_rst_i (sys_rst_i),
        .soft_rst_i(soft_rst_i),
        .wr_hit_i  (wr_hit[r]),
        .rd_hit_i  (rd_hit[r]),
        .wdata_i   (wdata_i[b]),
        .hw_i      (hw_i[IDX]),
        .q_o       (field_o[IDX]),
        .view_o    (view[IDX])
      );
    end
  end

  csr_rdmux #(
    .NUM_REGS(NUM_REGS),
    .DATA_W  (DATA_W)
  ) u_rdmux (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_i   (rd_i),
    .sel_i  (sel),
    .view_i (view),
    .rdata_o(rdata_o)
  );
endmodule

// File: tb/csr_bank_bench.sv
`timescale 1ns/1ps
module csr_bank_bench;
  localparam logic [31:0] HW_IDLE = 32'h0000_1000;  // latch-low input held high
  typedef logic [51:0] vec_t;  // {is_read, addr[2:0], wdata[7:0], hw[31:0], exp[7:0]}

  localparam int NV = 29;
  localparam vec_t VEC [NV] = '{
    {1'b1, 3'd0, 8'h00, 32'h0000_1000, 8'h05},  // R1 reg0 default
    {1'b1, 3'd1, 8'h00, 32'h0000_1000, 8'h10},  // R1 reg1 default
    {1'b1, 3'd3, 8'h00, 32'h0000_1000, 8'hA5},  // R1 reg3 default
    {1'b1, 3'd2, 8'h00, 32'h0000_1000, 8'h00},  // R10 reserved reg
    {1'b0, 3'd0, 8'hFF, 32'h0000_1000, 8'h00},
    {1'b1, 3'd0, 8'h00, 32'h0000_1000, 8'h07},  // R2 WO reads 0, R7 SC gone, R3 RO ignores write
    {1'b0, 3'd0, 8'h00, 32'h0000_1000, 8'h00},
    {1'b1, 3'd0, 8'h00, 32'h0000_1040, 8'h40},  // R3 RO shows input, R2 RW cleared
    {1'b0, 3'd1, 8'hFF, 32'h0000_1000, 8'h00},
    {1'b1, 3'd1, 8'h00, 32'h0000_1000, 8'h10},  // R5 R6 writes ignored
    {1'b0, 3'd1, 8'h00, 32'h0000_2F00, 8'h00},
    {1'b1, 3'd1, 8'h00, 32'h0000_1000, 8'h2F},  // R4 R5 R6 events captured, W1C write 0 no effect
    {1'b1, 3'd1, 8'h00, 32'h0000_1000, 8'h13},  // R5 R6 cleared and re-armed by read
    {1'b0, 3'd1, 8'h01, 32'h0000_1000, 8'h00},
    {1'b1, 3'd1, 8'h00, 32'h0000_1000, 8'h12},  // R4 write 1 clears
    {1'b0, 3'd1, 8'h02, 32'h0000_1100, 8'h00},
    {1'b1, 3'd1, 8'h00, 32'h0000_1000, 8'h11},  // R4
    {1'b0, 3'd1, 8'h01, 32'h0000_1100, 8'h00},
    {1'b1, 3'd1, 8'h00, 32'h0000_1000, 8'h11},  // R11 event beats write clear
    {1'b1, 3'd1, 8'h00, 32'h0000_2400, 8'h11},  // R11 read returns pre-event value
    {1'b1, 3'd1, 8'h00, 32'h0000_1000, 8'h25},  // R11 event beats read clear
    {1'b1, 3'd1, 8'h00, 32'h0000_1000, 8'h11},  // R5 R6
    {1'b0, 3'd3, 8'h3C, 32'h0000_1000, 8'h00},
    {1'b1, 3'd3, 8'h00, 32'h0000_1000, 8'h3C},  // R2
    {1'b0, 3'd2, 8'hFF, 32'h0000_1000, 8'h00},
    {1'b1, 3'd2, 8'h00, 32'h0000_1000, 8'h00},  // R10
    {1'b0, 3'd5, 8'hFF, 32'h0000_1000, 8'h00},
    {1'b1, 3'd5, 8'h00, 32'h0000_1000, 8'h00},  // R10 unmapped
    {1'b1, 3'd3, 8'h00, 32'h0000_1000, 8'h3C}   // R10 no alias
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sys_rst_i = 1'b0;
  logic        soft_rst_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic        wr_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic [31:0] hw_i = HW_IDLE;
  logic [7:0]  rdata_o;
  logic [31:0] field_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  csr_bank u_csr_bank (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .sys_rst_i (sys_rst_i),
    .soft_rst_i(soft_rst_i),
    .addr_i    (addr_i),
    .wr_i      (wr_i),
    .rd_i      (rd_i),
    .wdata_i   (wdata_i),
    .hw_i      (hw_i),
    .rdata_o   (rdata_o),
    .field_o   (field_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // one bus cycle; returns at the negedge after the sampling edge
  task automatic bus(input bit w, input bit r, input logic [2:0] a,
                     input logic [7:0] d, input logic [31:0] hw);
    @(negedge clk);
    wr_i = w; rd_i = r; addr_i = a; wdata_i = d; hw_i = hw;
    @(negedge clk);
    wr_i = 1'b0; rd_i = 1'b0; hw_i = HW_IDLE;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
    bus(1'b0, 1'b1, a, 8'h00, HW_IDLE);
    chk(tag, {24'h0, rdata_o}, {24'h0, exp});
  endtask

  task automatic pulse_soft(input bit sys);
    @(negedge clk);
    if (sys) sys_rst_i = 1'b1; else soft_rst_i = 1'b1;
    @(negedge clk);
    sys_rst_i = 1'b0; soft_rst_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rdata at reset", {24'h0, rdata_o}, 32'h0);
    chk("R1 field at reset", field_o, 32'hA500_1005);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      bus(~VEC[i][51], VEC[i][51], VEC[i][50:48], VEC[i][47:40], VEC[i][39:8]);
      if (VEC[i][51]) begin
        checks++;
        if (rdata_o !== VEC[i][7:0]) begin
          errors++;
          $display("FAIL table vector %0d actual %h expected %h", i, rdata_o, VEC[i][7:0]);
        end
      end
    end

    // R2 write-only drives field but reads 0
    bus(1'b1, 1'b0, 3'd0, 8'h0A, HW_IDLE);
    chk("R2 field after WO write", {24'h0, field_o[7:0]}, 32'h0A);
    rd_chk("R2 WO reads zero", 3'd0, 8'h02);
    chk("R1 rdata holds without read", {24'h0, rdata_o}, 32'h02);

    // R7 self-clearing: same-cycle read sees 1, gone next cycle
    bus(1'b1, 1'b1, 3'd0, 8'h1A, HW_IDLE);
    chk("R7 same-cycle read", {24'h0, rdata_o}, 32'h12);
    chk("R7 field set", {31'h0, field_o[4]}, 32'h1);
    @(negedge clk);
    chk("R7 field self-cleared", {31'h0, field_o[4]}, 32'h0);
    rd_chk("R7 read after clear", 3'd0, 8'h02);

    // R8 software reset keeps immune bits
    pulse_soft(1'b0);
    chk("R8 field after soft reset", field_o, 32'h3500_1001);
    rd_chk("R8 reg0 after soft reset", 3'd0, 8'h01);
    rd_chk("R8 reg3 after soft reset", 3'd3, 8'h35);
    rd_chk("R8 reg1 after soft reset", 3'd1, 8'h10);

    // R9 system reset restores all
    pulse_soft(1'b1);
    rd_chk("R9 reg0 after system reset", 3'd0, 8'h05);
    rd_chk("R9 reg3 after system reset", 3'd3, 8'hA5);

    // R1 power-on reset mid-run
    bus(1'b1, 1'b0, 3'd3, 8'h00, HW_IDLE);
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk("R1 field after power-on", field_o, 32'hA500_1005);
    chk("R1 rdata after power-on", {24'h0, rdata_o}, 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    rd_chk("R1 reg3 after power-on", 3'd3, 8'hA5);

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule